// File: doc/BRIEF.md
# MOESI Snooping Line Coherence Controller

This block tracks the coherence state of a single cache line held in one private cache that sits on a shared snooping bus. The line is always in one of five states: invalid, shared, exclusive, owned or modified. The owned state lets a dirty line stay shared among caches without a write-back to memory. The cache core presents read, write and replace requests together with a tag-match flag. The controller decides whether a request can complete locally or needs a bus transaction, issues that transaction, samples the wired shared line in the response cycle and then settles the new state.

On the snoop side the controller watches transactions from other caches and answers them. It drives the shared line and an intervention flag one cycle later, and it updates the local state. A modified or owned line always supplies data on a snooped read or read-for-ownership. An exclusive line supplies data only when the compile-time parameter `EXCL_INTV` is set. Snoops take priority over the one processor request that may be pending, and that request is re-evaluated against the updated state. The data array, tag compare, arbitration and memory are outside this block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: While and after `rst` is high, `line_state` is invalid (code 0), and `bus_req_valid`, `cpu_busy`, `cpu_done`, `snp_shared_out` and `snp_supply_out` are low. State codes: I=0, S=1, E=2, O=3, M=4.
- R2: A read with no line hit issues bus command READ (code 0). If `bus_shared_in` is high in the cycle after the grant, the line becomes S; otherwise it becomes E.
- R3: A write that hits a line in M or E completes with no bus request and leaves the line in M.
- R4: A write that hits a line in O or S issues INVALIDATE (code 2). After the grant the line becomes M.
- R5: A write with no line hit (tag miss or state I) issues RWITM (code 1). After the grant the line becomes M.
- R6: A snooped READ that hits M moves the line to O, E to S, and leaves O and S unchanged. Intervention is asserted in the response cycle for M and O, and for E only when `EXCL_INTV` is 1.
- R7: A snooped RWITM or INVALIDATE that hits a valid line moves it to I. RWITM asserts intervention for M, O and (with `EXCL_INTV`) E. INVALIDATE never asserts intervention.
- R8: `snp_shared_out` is high in the cycle after a snoop exactly when the snoop hits the tag, the line is not I, and the command is not WRITEBACK (code 3). A snoop that misses the tag, finds the line in I, or carries WRITEBACK changes nothing.
- R9: A replace of a hit line in M or O issues WRITEBACK (code 3) and then sets I. A replace of E or S sets I with no bus request.
- R10: A snoop that arrives while a request is being evaluated or waiting for a grant is serviced first. The bus request is withdrawn the next cycle, and the request is decided again from the new state.
- R11: A read hit completes locally with the state unchanged. `cpu_done` is a one-cycle pulse two cycles after acceptance for local completion, or two cycles after the grant. `cpu_busy` is high from the cycle after acceptance until `cpu_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Request strobe, taken only when `cpu_busy` is low |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 replace |
| cpu_hit | input | 1 | Tag of the request matches this line |
| cpu_busy | output | 1 | A request is in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| line_state | output | 3 | Current coherence state code |
| bus_req_valid | output | 1 | Bus transaction requested, held until granted or withdrawn |
| bus_req_cmd | output | 2 | 0 READ, 1 RWITM, 2 INVALIDATE, 3 WRITEBACK |
| bus_gnt | input | 1 | Own transaction is on the bus this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from other caches, sampled in the cycle after the grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_req_cmd` |
| snp_hit | input | 1 | Snooped address matches this line's tag |
| snp_shared_out | output | 1 | Drive of the shared line in the snoop response cycle |
| snp_supply_out | output | 1 | This cache supplies the data (intervention) |

## Verification
Every result of this block has a fixed delay. A snoop presented in cycle t shows its shared and intervention response, and its new state, in cycle t+1. A request accepted in cycle a is evaluated in a+1, so a local completion shows `cpu_done` and its state in a+2, and a needed bus request shows in a+2. A grant in cycle g is followed by shared-line sampling in g+1 and the final state with `cpu_done` in g+2. The bench's behavioural model advances on each rising edge from the inputs that are stable at that edge. The outputs are compared one time unit after the edge, so every check lands in the cycle in which the registered result is due.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  localparam int ST_W  = 3;
  localparam int CMD_W = 2;
  localparam int OP_W  = 2;

  typedef enum logic [ST_W-1:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4
  } line_st_t;

  typedef enum logic [CMD_W-1:0] {
    BC_READ = 2'd0, BC_RWITM = 2'd1, BC_INV = 2'd2, BC_WB = 2'd3
  } bus_cmd_t;

  typedef enum logic [OP_W-1:0] {
    OP_READ = 2'd0, OP_WRITE = 2'd1, OP_REPL = 2'd2, OP_NONE = 2'd3
  } cpu_op_t;
endpackage

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
  import moesi_pkg::*;
#(
  parameter bit EXCL_INTV = 1'b1
) (
  input  line_st_t cur_st,
  input  logic     snp_valid,
  input  bus_cmd_t snp_cmd,
  input  logic     snp_hit,
  output logic     act,
  output line_st_t nxt_st,
  output logic     resp_shared,
  output logic     resp_supply
);
  logic owner;
  logic wants_data;

  always_comb begin
    act        = snp_valid && snp_hit && (cur_st != ST_I) && (snp_cmd != BC_WB);
    owner      = (cur_st == ST_M) || (cur_st == ST_O) || (EXCL_INTV && (cur_st == ST_E));
    wants_data = (snp_cmd == BC_READ) || (snp_cmd == BC_RWITM);
    resp_shared = act;
    resp_supply = act && owner && wants_data;
    nxt_st = cur_st;
    unique case (snp_cmd)
      BC_READ: begin
        if (cur_st == ST_M)      nxt_st = ST_O;
        else if (cur_st == ST_E) nxt_st = ST_S;
      end
      BC_RWITM, BC_INV: nxt_st = ST_I;
      default: nxt_st = cur_st;
    endcase
  end
endmodule

// File: rtl/moesi_req_unit.sv
module moesi_req_unit
  import moesi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  line_st_t         cur_st,
  input  logic             req_valid,
  input  logic [OP_W-1:0]  req_op,
  input  logic             req_hit,
  input  logic             snp_valid,
  input  logic             bus_gnt,
  input  logic             bus_shared_in,
  output logic             upd_valid,
  output line_st_t         upd_st,
  output logic             bus_req_valid,
  output logic [CMD_W-1:0] bus_req_cmd,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {F_IDLE, F_EVAL, F_ISSUE, F_RESP} fsm_t;

  fsm_t     fsm_q;
  cpu_op_t  op_q;
  logic     hit_q;
  bus_cmd_t cmd_q;
  logic     line_hit;
  logic     need_bus;
  bus_cmd_t want_cmd;
  logic     set_st;
  line_st_t set_val;
  line_st_t resp_st;

  always_comb begin
    line_hit = hit_q && (cur_st != ST_I);
    need_bus = 1'b0;
    want_cmd = BC_READ;
    set_st   = 1'b0;
    set_val  = cur_st;
    unique case (op_q)
      OP_READ: need_bus = !line_hit;
      OP_WRITE: begin
        if (line_hit && ((cur_st == ST_M) || (cur_st == ST_E))) begin
          set_st  = 1'b1;
          set_val = ST_M;
        end else begin
          need_bus = 1'b1;
          want_cmd = line_hit ? BC_INV : BC_RWITM;
        end
      end
      OP_REPL: begin
        if (line_hit && ((cur_st == ST_M) || (cur_st == ST_O))) begin
          need_bus = 1'b1;
          want_cmd = BC_WB;
        end else if (line_hit) begin
          set_st  = 1'b1;
          set_val = ST_I;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (cmd_q)
      BC_READ: resp_st = bus_shared_in ? ST_S : ST_E;
      BC_WB:   resp_st = ST_I;
      default: resp_st = ST_M;
    endcase
    upd_valid = ((fsm_q == F_EVAL) && !snp_valid && set_st && !need_bus) || (fsm_q == F_RESP);
    upd_st    = (fsm_q == F_RESP) ? resp_st : set_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q         <= F_IDLE;
      op_q          <= OP_NONE;
      hit_q         <= 1'b0;
      cmd_q         <= BC_READ;
      bus_req_valid <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (fsm_q)
        F_IDLE: if (req_valid) begin
          op_q  <= cpu_op_t'(req_op);
          hit_q <= req_hit;
          busy  <= 1'b1;
          fsm_q <= F_EVAL;
        end
        F_EVAL: if (!snp_valid) begin
          if (need_bus) begin
            cmd_q         <= want_cmd;
            bus_req_valid <= 1'b1;
            fsm_q         <= F_ISSUE;
          end else begin
            done  <= 1'b1;
            busy  <= 1'b0;
            fsm_q <= F_IDLE;
          end
        end
        F_ISSUE: begin
          if (snp_valid) begin
            bus_req_valid <= 1'b0;
            fsm_q         <= F_EVAL;
          end else if (bus_gnt) begin
            bus_req_valid <= 1'b0;
            fsm_q         <= F_RESP;
          end
        end
        F_RESP: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          fsm_q <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign bus_req_cmd = cmd_q;
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter bit EXCL_INTV = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req_valid,
  input  logic [OP_W-1:0]  cpu_req_op,
  input  logic             cpu_hit,
  output logic             cpu_busy,
  output logic             cpu_done,
  output logic [ST_W-1:0]  line_state,
  output logic             bus_req_valid,
  output logic [CMD_W-1:0] bus_req_cmd,
  input  logic             bus_gnt,
  input  logic             bus_shared_in,
  input  logic             snp_valid,
  input  logic [CMD_W-1:0] snp_cmd,
  input  logic             snp_hit,
  output logic             snp_shared_out,
  output logic             snp_supply_out
);
  line_st_t st_q;
  line_st_t snp_nxt;
  line_st_t upd_st;
  logic     snp_act;
  logic     snp_sh;
  logic     snp_sup;
  logic     upd_valid;

  moesi_snoop_unit #(.EXCL_INTV(EXCL_INTV)) u_snoop (
    .cur_st      (st_q),
    .snp_valid   (snp_valid),
    .snp_cmd     (bus_cmd_t'(snp_cmd)),
    .snp_hit     (snp_hit),
    .act         (snp_act),
    .nxt_st      (snp_nxt),
    .resp_shared (snp_sh),
    .resp_supply (snp_sup)
  );

  moesi_req_unit u_req (
    .clk           (clk),
    .rst           (rst),
    .cur_st        (st_q),
    .req_valid     (cpu_req_valid),
    .req_op        (cpu_req_op),
    .req_hit       (cpu_hit),
    .snp_valid     (snp_valid),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .upd_valid     (upd_valid),
    .upd_st        (upd_st),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (bus_req_cmd),
    .busy          (cpu_busy),
    .done          (cpu_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_I;
      snp_shared_out <= 1'b0;
      snp_supply_out <= 1'b0;
    end else begin
      snp_shared_out <= snp_sh;
      snp_supply_out <= snp_sup;
      if (snp_act)        st_q <= snp_nxt;
      else if (upd_valid) st_q <= upd_st;
    end
  end

  assign line_state = st_q;
endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk
  import moesi_pkg::*;
#(
  parameter bit EXCL_INTV = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_busy,
  input logic             cpu_done,
  input logic [ST_W-1:0]  line_state,
  input logic             bus_req_valid,
  input logic             bus_gnt,
  input logic             snp_valid,
  input logic [CMD_W-1:0] snp_cmd,
  input logic             snp_hit,
  input logic             snp_shared_out,
  input logic             snp_supply_out
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (line_state == ST_I) && !bus_req_valid && !cpu_busy && !cpu_done);

  p_m_entry_r4: assert property (@(posedge clk) disable iff (rst)
    ((line_state == ST_M) && ($past(line_state) != ST_M))
      |-> (($past(line_state) == ST_E) || $past(bus_gnt, 2)));

  p_snoop_read_m_r6: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_hit && (snp_cmd == BC_READ) && (line_state == ST_M))
      |=> (line_state == ST_O) && snp_supply_out && snp_shared_out);

  p_snoop_kill_r7: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_hit && ((snp_cmd == BC_RWITM) || (snp_cmd == BC_INV)) && (line_state != ST_I))
      |=> (line_state == ST_I) && snp_shared_out);

  p_quiet_snoop_r8: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && (!snp_hit || (line_state == ST_I) || (snp_cmd == BC_WB)))
      |=> !snp_shared_out && !snp_supply_out && $stable(line_state));

  p_withdraw_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && snp_valid) |=> !bus_req_valid);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.EXCL_INTV(EXCL_INTV)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cpu_busy       (cpu_busy),
  .cpu_done       (cpu_done),
  .line_state     (line_state),
  .bus_req_valid  (bus_req_valid),
  .bus_gnt        (bus_gnt),
  .snp_valid      (snp_valid),
  .snp_cmd        (snp_cmd),
  .snp_hit        (snp_hit),
  .snp_shared_out (snp_shared_out),
  .snp_supply_out (snp_supply_out)
);

// File: tb/moesi_line_ctrl_tb_top.sv
module moesi_line_ctrl_tb_top;
  localparam bit EX = 1'b1;
  localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;
  localparam int CRD = 0, CRW = 1, CINV = 2, CWB = 3;
  localparam int NOBUS = -1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_req_valid = 1'b0;
  logic [1:0] cpu_req_op = 2'd0;
  logic       cpu_hit = 1'b0;
  logic       cpu_busy, cpu_done;
  logic [2:0] line_state;
  logic       bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic       bus_gnt = 1'b0;
  logic       bus_shared_in = 1'b0;
  logic       snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic       snp_hit = 1'b0;
  logic       snp_shared_out, snp_supply_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  moesi_line_ctrl #(.EXCL_INTV(EX)) dut_i (
    .clk(clk), .rst(rst), .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op),
    .cpu_hit(cpu_hit), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .line_state(line_state),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_gnt(bus_gnt),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_hit(snp_hit), .snp_shared_out(snp_shared_out), .snp_supply_out(snp_supply_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st = SI, m_phase = 0, m_op = 0, m_hit = 0, m_cmd = 0;
  int m_breq = 0, m_done = 0, m_busy = 0, m_sh = 0, m_iv = 0;

  task automatic model_step();
    int ns, bus, loc;
    bit touch, lh;
    if (rst) begin
      m_st = SI; m_phase = 0; m_breq = 0; m_done = 0; m_busy = 0; m_sh = 0; m_iv = 0;
      return;
    end
    ns = m_st;
    touch = snp_valid && snp_hit && m_st != SI && int'(snp_cmd) != CWB;
    m_done = 0;
    if (touch) begin
      if (int'(snp_cmd) == CRD) ns = (m_st == SM) ? SO : ((m_st == SE) ? SS : m_st);
      else ns = SI;
    end
    if (m_phase == 0) begin
      if (cpu_req_valid) begin
        m_op = int'(cpu_req_op); m_hit = int'(cpu_hit); m_phase = 1; m_busy = 1;
      end
    end else if (m_phase == 1) begin
      if (!snp_valid) begin
        lh = (m_hit != 0) && m_st != SI;
        bus = NOBUS; loc = -1;
        if (m_op == 0 && !lh) bus = CRD;
        if (m_op == 1) begin
          if (lh && (m_st == SM || m_st == SE)) loc = SM;
          else bus = lh ? CINV : CRW;
        end
        if (m_op == 2) begin
          if (lh && (m_st == SM || m_st == SO)) bus = CWB;
          else if (lh) loc = SI;
        end
        if (bus != NOBUS) begin
          m_cmd = bus; m_breq = 1; m_phase = 2;
        end else begin
          if (loc >= 0) ns = loc;
          m_done = 1; m_busy = 0; m_phase = 0;
        end
      end
    end else if (m_phase == 2) begin
      if (snp_valid) begin m_breq = 0; m_phase = 1; end
      else if (bus_gnt) begin m_breq = 0; m_phase = 3; end
    end else begin
      if (!touch) ns = (m_cmd == CRD) ? (bus_shared_in ? SS : SE) : ((m_cmd == CWB) ? SI : SM);
      m_done = 1; m_busy = 0; m_phase = 0;
    end
    m_sh = touch ? 1 : 0;
    m_iv = (touch && int'(snp_cmd) <= CRW && (m_st == SM || m_st == SO || (EX && m_st == SE))) ? 1 : 0;
    m_st = ns;
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    chk(int'(line_state) == m_st, "R4 model state", int'(line_state), m_st);
    chk(int'(bus_req_valid) == m_breq, "R5 model bus request", int'(bus_req_valid), m_breq);
    if (m_breq != 0) chk(int'(bus_req_cmd) == m_cmd, "R5 model bus command", int'(bus_req_cmd), m_cmd);
    chk(int'(cpu_done) == m_done, "R11 model done", int'(cpu_done), m_done);
    chk(int'(cpu_busy) == m_busy, "R10 model busy", int'(cpu_busy), m_busy);
    chk(int'(snp_shared_out) == m_sh, "R8 model shared", int'(snp_shared_out), m_sh);
    chk(int'(snp_supply_out) == m_iv, "R6 model supply", int'(snp_supply_out), m_iv);
  end

  task automatic run_req(input int op, input int hit, input int sh, input int exp_cmd,
                         input int exp_st, input string req);
    int seen = NOBUS;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = 2'(op); cpu_hit = hit[0];
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (cpu_done) break;
      if (bus_req_valid) begin
        seen = int'(bus_req_cmd);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0; bus_shared_in = sh[0];
        @(negedge clk);
        bus_shared_in = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(cpu_done == 1'b1, {req, " completion"}, int'(cpu_done), 1);
    chk(seen == exp_cmd, {req, " bus command"}, seen, exp_cmd);
    chk(int'(line_state) == exp_st, {req, " final state"}, int'(line_state), exp_st);
  endtask

  task automatic run_snoop(input int cmd, input int hit, input int exp_sh, input int exp_iv,
                           input int exp_st, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_hit = hit[0];
    @(negedge clk);
    snp_valid = 1'b0; snp_hit = 1'b0;
    chk(int'(snp_shared_out) == exp_sh, {req, " shared"}, int'(snp_shared_out), exp_sh);
    chk(int'(snp_supply_out) == exp_iv, {req, " supply"}, int'(snp_supply_out), exp_iv);
    chk(int'(line_state) == exp_st, {req, " state"}, int'(line_state), exp_st);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_state == 3'd0 && !bus_req_valid && !cpu_busy, "R1 reset", int'(line_state), SI);
    rst = 1'b0;
    @(negedge clk);
    chk(!snp_shared_out && !snp_supply_out && !cpu_done, "R1 after reset", int'(snp_shared_out), 0);

    run_req(0, 1, 0, CRD, SE, "R2 read miss alone");
    run_snoop(CRD, 1, 1, 1, SS, "R6 snoop read on E");
    run_req(1, 1, 0, CINV, SM, "R4 write hit S");
    run_snoop(CRD, 1, 1, 1, SO, "R6 snoop read on M");
    run_snoop(CRD, 1, 1, 1, SO, "R6 snoop read on O");
    run_req(0, 1, 0, NOBUS, SO, "R11 read hit O");
    run_snoop(CRD, 0, 0, 0, SO, "R8 snoop tag miss");
    run_snoop(CWB, 1, 0, 0, SO, "R8 snoop writeback");
    run_req(1, 1, 0, CINV, SM, "R4 write hit O");
    run_req(1, 1, 0, NOBUS, SM, "R3 write hit M");
    run_req(2, 1, 0, CWB, SI, "R9 replace M");
    run_snoop(CRD, 1, 0, 0, SI, "R8 snoop on invalid");
    run_req(1, 1, 0, CRW, SM, "R5 write miss from I");
    run_snoop(CRW, 1, 1, 1, SI, "R7 snoop rwitm on M");
    run_req(0, 1, 1, CRD, SS, "R2 read miss shared");
    run_snoop(CINV, 1, 1, 0, SI, "R7 snoop invalidate");
    run_req(0, 1, 0, CRD, SE, "R2 read miss again");
    run_req(1, 1, 0, NOBUS, SM, "R3 write hit E");
    run_snoop(CRD, 1, 1, 1, SO, "R6 make owned");
    run_req(2, 1, 0, CWB, SI, "R9 replace O");
    run_req(0, 1, 0, CRD, SE, "R2 refill");
    run_req(2, 1, 0, NOBUS, SI, "R9 replace E silent");
    run_req(0, 1, 1, CRD, SS, "R2 refill shared");
    run_req(1, 0, 0, CRW, SM, "R5 write tag miss");
    run_snoop(CRD, 1, 1, 1, SO, "R6 owned again");
    run_snoop(CRD, 1, 1, 1, SO, "R6 owned stays");
    run_snoop(CRW, 1, 1, 1, SI, "R7 snoop rwitm on O");
    run_req(0, 1, 1, CRD, SS, "R2 shared for R10");

    // R10: pending invalidate overtaken by a snooped invalidate
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = 2'd1; cpu_hit = 1'b1;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (bus_req_valid) break;
      @(negedge clk);
    end
    chk(bus_req_valid && int'(bus_req_cmd) == CINV, "R10 first command", int'(bus_req_cmd), CINV);
    snp_valid = 1'b1; snp_cmd = 2'(CINV); snp_hit = 1'b1;
    @(negedge clk);
    snp_valid = 1'b0; snp_hit = 1'b0;
    chk(!bus_req_valid, "R10 request withdrawn", int'(bus_req_valid), 0);
    chk(int'(line_state) == SI, "R10 snoop served first", int'(line_state), SI);
    for (int k = 0; k < 10; k++) begin
      if (bus_req_valid) break;
      @(negedge clk);
    end
    chk(int'(bus_req_cmd) == CRW, "R10 reissued as rwitm", int'(bus_req_cmd), CRW);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    @(negedge clk);
    chk(cpu_done && int'(line_state) == SM, "R10 final state", int'(line_state), SM);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule